// File: doc/BRIEF.md
# Mailbox Doorbell Register Bank

This block carries short messages between a processor on the local side of a chip and a remote host. Each direction has eight 32-bit mailbox words. A side may write only its outbound set, while both sets can be read from either side. Writing an outbound mailbox rings a doorbell on the opposite side: it raises a sticky pending bit in that side's status register. Software there clears the bit by writing a 1 to it. A per-side enable mask selects which pending bits drive that side's level interrupt.

Each side has its own register port with a byte address, a write strobe with byte enables, a read strobe and a 32-bit data path. The port has no stalls, and every read returns its word one cycle after the strobe. Both sides decode the same map. Status is at 0x3060 and the interrupt mask is at 0x3070, with the doorbell bits at positions 23:16. The local-outbound mailboxes are at 0x3A00..0x3A1C and the host-outbound mailboxes are at 0x3B00..0x3B1C, one word every 4 bytes. Each side's decoder classifies an access into one of five access kinds. None means unmapped or misaligned, Status, Enable, Outbound-mailbox and Inbound-mailbox are the others. The kind of the current access alone selects what the port does in that cycle. All state sits on one clock with an asynchronous active-low reset.

Top module: `mbx_doorbell_bank`

## Requirements
- R1: After reset every mailbox, status bit and enable bit is zero, both interrupts are low, both read-valid outputs are low and read data is zero.
- R2: A local write to 0x3A00+4n updates only the byte lanes whose enables are set in local-to-host mailbox n. The word then reads back the same from both sides.
- R3: Writes to the other side's outbound range are ignored: local writes to 0x3B00..0x3B1F and host writes to 0x3A00..0x3A1F change no mailbox and no status bit.
- R4: A write with at least one byte enable to a side's outbound mailbox n sets status bit 16+n at 0x3060 on the opposite side. A write with all byte enables low has no effect anywhere.
- R5: A status write with byte enable 2 set clears every bit 23:16 whose written data bit is 1 and leaves bits written 0 unchanged. Without byte enable 2, the write changes no status bit.
- R6: When a doorbell set and a write-one-to-clear hit the same status bit in one cycle, the bit ends set.
- R7: Bits 23:16 of the enable register at 0x3070 are read/write, updated only when byte enable 2 is set.
- R8: Status and enable bits 15:0 and 31:24 always read zero, whatever is written.
- R9: A side's interrupt is registered. It goes high the cycle after some status bit and its enable bit are both 1, and low the cycle after no such pair remains, whether by clearing or masking.
- R10: A read strobe gives read-valid and the addressed word in the next cycle, holding the state before that edge. Misaligned or unmapped addresses read zero and ignore writes. Read data is zero in cycles without read-valid.
- R11: Both ports operate in the same cycle without interfering; simultaneous writes from the two sides both take effect and ring both doorbells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_addr | input | 16 | Local byte address |
| lcl_wr | input | 1 | Local write strobe |
| lcl_rd | input | 1 | Local read strobe |
| lcl_be | input | 4 | Local byte enables |
| lcl_wdata | input | 32 | Local write data |
| lcl_rdata | output | 32 | Local read data, one cycle after the strobe |
| lcl_rvalid | output | 1 | Local read data valid |
| lcl_irq | output | 1 | Local level interrupt |
| hst_addr | input | 16 | Host byte address |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the strobe |
| hst_rvalid | output | 1 | Host read data valid |
| hst_irq | output | 1 | Host level interrupt |

## Verification
The doorbell path is driven with full-word writes, partial and all-zero byte enables, and writes to the wrong side's range. These separate lane merging, the rule that an empty write is no write, and the per-side ownership of the mailboxes. Status clears are tried with zero data, with lane 2 disabled, and in the same cycle as a doorbell on that bit, which sorts a correct clear from a lost event. The interrupt is raised, masked, unmasked and cleared, and its edges are checked one cycle after each cause. Simultaneous writes from both sides show that the two ports stay independent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_DATA_W = 32;
    localparam int unsigned MBX_ADDR_W = 16;
    localparam int unsigned MBX_COUNT  = 8;
    localparam int unsigned MBX_DB_LSB = 16;

    // Kind of register access the current address selects
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STS,
        ACC_ENA,
        ACC_OUT,
        ACC_IN
    } acc_kind_e;

endpackage

// File: rtl/mbx_mailbox_array.sv
module mbx_mailbox_array #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_MBX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MBX-1:0]  wr_sel,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   mbx_q [NUM_MBX]
);

    localparam int unsigned LANES = DATA_W / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MBX; i++) begin
                mbx_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_MBX; i++) begin
                for (int b = 0; b < LANES; b++) begin
                    if (wr_sel[i] && be[b]) begin
                        mbx_q[i][b*8 +: 8] <= wdata[b*8 +: 8];
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_MBX; g++) begin : g_chk
        AST_MBX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel[g] |=> $stable(mbx_q[g])); // R3
    end

endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
#(
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       NUM_MBX  = 8,
    parameter int unsigned       DB_LSB   = 16,
    parameter logic [ADDR_W-1:0] STS_OFS  = 'h3060,
    parameter logic [ADDR_W-1:0] ENA_OFS  = 'h3070,
    parameter logic [ADDR_W-1:0] OUT_BASE = 'h3A00,
    parameter logic [ADDR_W-1:0] IN_BASE  = 'h3B00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                rd,
    input  logic [DATA_W/8-1:0] be,
    input  logic [NUM_MBX-1:0]  db_wdata,
    input  logic [NUM_MBX-1:0]  ring_in,
    input  logic [DATA_W-1:0]   out_mbx [NUM_MBX],
    input  logic [DATA_W-1:0]   in_mbx [NUM_MBX],
    output logic [NUM_MBX-1:0]  out_wr,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid,
    output logic                irq
);

    localparam int unsigned IDX_W   = $clog2(NUM_MBX);
    localparam int unsigned WIN_LSB = IDX_W + 2;

    acc_kind_e          acc;
    logic               aligned;
    logic               wr_go;
    logic [IDX_W-1:0]   idx;
    logic [NUM_MBX-1:0] sts_q;
    logic [NUM_MBX-1:0] ena_q;
    logic [NUM_MBX-1:0] clr_vec;
    logic [NUM_MBX-1:0] ena_we;
    logic [DATA_W-1:0]  rd_mux;

    assign aligned = (addr[1:0] == 2'b00);
    assign wr_go   = wr && (|be);
    assign idx     = addr[WIN_LSB-1:2];

    // Access decoder
    always_comb begin
        acc = ACC_NONE;
        if (!aligned) begin
            acc = ACC_NONE;
        end else if (addr[ADDR_W-1:2] == STS_OFS[ADDR_W-1:2]) begin
            acc = ACC_STS;
        end else if (addr[ADDR_W-1:2] == ENA_OFS[ADDR_W-1:2]) begin
            acc = ACC_ENA;
        end else if (addr[ADDR_W-1:WIN_LSB] == OUT_BASE[ADDR_W-1:WIN_LSB]) begin
            acc = ACC_OUT;
        end else if (addr[ADDR_W-1:WIN_LSB] == IN_BASE[ADDR_W-1:WIN_LSB]) begin
            acc = ACC_IN;
        end
    end

    // Per-doorbell-bit strobes, each tied to the byte lane holding the bit
    for (genvar g = 0; g < NUM_MBX; g++) begin : g_bit
        localparam int unsigned LANE = (DB_LSB + g) / 8;
        assign out_wr[g]  = wr_go && (acc == ACC_OUT) && (idx == IDX_W'(g));
        assign clr_vec[g] = wr_go && (acc == ACC_STS) && be[LANE] && db_wdata[g];
        assign ena_we[g]  = wr_go && (acc == ACC_ENA) && be[LANE];
    end

    // Status, enable and interrupt registers: a doorbell set beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            ena_q <= '0;
            irq   <= 1'b0;
        end else begin
            sts_q <= ring_in | (sts_q & ~clr_vec);
            ena_q <= (ena_q & ~ena_we) | (db_wdata & ena_we);
            irq   <= |(sts_q & ena_q);
        end
    end

    // Read selection
    always_comb begin
        rd_mux = '0;
        unique case (acc)
            ACC_NONE: rd_mux = '0;
            ACC_STS:  rd_mux[DB_LSB +: NUM_MBX] = sts_q;
            ACC_ENA:  rd_mux[DB_LSB +: NUM_MBX] = ena_q;
            ACC_OUT:  rd_mux = out_mbx[idx];
            ACC_IN:   rd_mux = in_mbx[idx];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rdata  <= rd ? rd_mux : '0;
            rvalid <= rd;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ring_in) |=> ((sts_q & $past(ring_in)) == $past(ring_in))); // R6
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((~|clr_vec) && (~|ring_in)) |=> $stable(sts_q)); // R5
    AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (~|ena_we) |=> $stable(ena_q)); // R7
    AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_q & ena_q)) |=> irq); // R9
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(sts_q & ena_q)) |=> !irq); // R9
    AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid); // R10
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0)); // R10
    AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_wr)); // R2

endmodule

// File: rtl/mbx_doorbell_bank.sv
module mbx_doorbell_bank
    import mbx_pkg::*;
#(
    parameter int unsigned       DATA_W   = MBX_DATA_W,
    parameter int unsigned       ADDR_W   = MBX_ADDR_W,
    parameter int unsigned       NUM_MBX  = MBX_COUNT,
    parameter int unsigned       DB_LSB   = MBX_DB_LSB,
    parameter logic [ADDR_W-1:0] STS_OFS  = 'h3060,
    parameter logic [ADDR_W-1:0] ENA_OFS  = 'h3070,
    parameter logic [ADDR_W-1:0] L2H_BASE = 'h3A00,
    parameter logic [ADDR_W-1:0] H2L_BASE = 'h3B00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   lcl_addr,
    input  logic                lcl_wr,
    input  logic                lcl_rd,
    input  logic [DATA_W/8-1:0] lcl_be,
    input  logic [DATA_W-1:0]   lcl_wdata,
    output logic [DATA_W-1:0]   lcl_rdata,
    output logic                lcl_rvalid,
    output logic                lcl_irq,
    input  logic [ADDR_W-1:0]   hst_addr,
    input  logic                hst_wr,
    input  logic                hst_rd,
    input  logic [DATA_W/8-1:0] hst_be,
    input  logic [DATA_W-1:0]   hst_wdata,
    output logic [DATA_W-1:0]   hst_rdata,
    output logic                hst_rvalid,
    output logic                hst_irq
);

    logic [NUM_MBX-1:0] lcl_out_wr;
    logic [NUM_MBX-1:0] hst_out_wr;
    logic [DATA_W-1:0]  l2h_q [NUM_MBX];
    logic [DATA_W-1:0]  h2l_q [NUM_MBX];

    mbx_mailbox_array #(.DATA_W(DATA_W), .NUM_MBX(NUM_MBX)) u_l2h (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (lcl_out_wr),
        .be     (lcl_be),
        .wdata  (lcl_wdata),
        .mbx_q  (l2h_q)
    );

    mbx_mailbox_array #(.DATA_W(DATA_W), .NUM_MBX(NUM_MBX)) u_h2l (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (hst_out_wr),
        .be     (hst_be),
        .wdata  (hst_wdata),
        .mbx_q  (h2l_q)
    );

    mbx_side #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_MBX(NUM_MBX), .DB_LSB(DB_LSB),
        .STS_OFS(STS_OFS), .ENA_OFS(ENA_OFS),
        .OUT_BASE(L2H_BASE), .IN_BASE(H2L_BASE)
    ) u_lcl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (lcl_addr),
        .wr       (lcl_wr),
        .rd       (lcl_rd),
        .be       (lcl_be),
        .db_wdata (lcl_wdata[DB_LSB +: NUM_MBX]),
        .ring_in  (hst_out_wr),
        .out_mbx  (l2h_q),
        .in_mbx   (h2l_q),
        .out_wr   (lcl_out_wr),
        .rdata    (lcl_rdata),
        .rvalid   (lcl_rvalid),
        .irq      (lcl_irq)
    );

    mbx_side #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_MBX(NUM_MBX), .DB_LSB(DB_LSB),
        .STS_OFS(STS_OFS), .ENA_OFS(ENA_OFS),
        .OUT_BASE(H2L_BASE), .IN_BASE(L2H_BASE)
    ) u_hst (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (hst_addr),
        .wr       (hst_wr),
        .rd       (hst_rd),
        .be       (hst_be),
        .db_wdata (hst_wdata[DB_LSB +: NUM_MBX]),
        .ring_in  (lcl_out_wr),
        .out_mbx  (h2l_q),
        .in_mbx   (l2h_q),
        .out_wr   (hst_out_wr),
        .rdata    (hst_rdata),
        .rvalid   (hst_rvalid),
        .irq      (hst_irq)
    );

endmodule

// File: tb/mbx_doorbell_bank_tb.sv
`timescale 1ns/1ps
module mbx_doorbell_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lcl_addr = '0, hst_addr = '0;
    logic        lcl_wr = 1'b0, lcl_rd = 1'b0, hst_wr = 1'b0, hst_rd = 1'b0;
    logic [3:0]  lcl_be = '0, hst_be = '0;
    logic [31:0] lcl_wdata = '0, hst_wdata = '0;
    logic [31:0] lcl_rdata, hst_rdata;
    logic        lcl_rvalid, hst_rvalid, lcl_irq, hst_irq;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    mbx_doorbell_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .lcl_addr(lcl_addr), .lcl_wr(lcl_wr), .lcl_rd(lcl_rd), .lcl_be(lcl_be),
        .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata), .lcl_rvalid(lcl_rvalid), .lcl_irq(lcl_irq),
        .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_be(hst_be),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .hst_irq(hst_irq)
    );

    // Behavioural reference model
    bit [31:0] m_l2h [8];
    bit [31:0] m_h2l [8];
    bit [7:0]  m_lsts, m_hsts, m_lena, m_hena;
    bit [31:0] m_lrd, m_hrd;
    bit        m_lrv, m_hrv, m_lirq, m_hirq;

    function automatic bit [31:0] merge(bit [31:0] o, bit [31:0] n, bit [3:0] be);
        for (int b = 0; b < 4; b++) if (be[b]) o[b*8 +: 8] = n[b*8 +: 8];
        return o;
    endfunction

    function automatic bit [31:0] mread(bit host, bit [15:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 16'h3060) return {8'h0, (host ? m_hsts : m_lsts), 16'h0};
        if (a == 16'h3070) return {8'h0, (host ? m_hena : m_lena), 16'h0};
        if (a[15:5] == 11'h1D0) return m_l2h[a[4:2]];
        if (a[15:5] == 11'h1D8) return m_h2l[a[4:2]];
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_l2h[i] = 0; m_h2l[i] = 0; end
            m_lsts = 0; m_hsts = 0; m_lena = 0; m_hena = 0;
            m_lrd = 0; m_hrd = 0; m_lrv = 0; m_hrv = 0; m_lirq = 0; m_hirq = 0;
        end else begin
            bit [7:0]  lset, hset, lclr, hclr;
            bit [31:0] lr, hr;
            bit        li, hi;
            lset = 0; hset = 0; lclr = 0; hclr = 0;
            li = |(m_lsts & m_lena);
            hi = |(m_hsts & m_hena);
            lr = lcl_rd ? mread(1'b0, lcl_addr) : 32'h0;
            hr = hst_rd ? mread(1'b1, hst_addr) : 32'h0;
            if (lcl_wr && (|lcl_be) && lcl_addr[1:0] == 2'b00) begin
                if (lcl_addr[15:5] == 11'h1D0) begin
                    m_l2h[lcl_addr[4:2]] = merge(m_l2h[lcl_addr[4:2]], lcl_wdata, lcl_be);
                    hset[lcl_addr[4:2]] = 1'b1;
                end else if (lcl_addr == 16'h3060 && lcl_be[2]) lclr = lcl_wdata[23:16];
                else if (lcl_addr == 16'h3070 && lcl_be[2]) m_lena = lcl_wdata[23:16];
            end
            if (hst_wr && (|hst_be) && hst_addr[1:0] == 2'b00) begin
                if (hst_addr[15:5] == 11'h1D8) begin
                    m_h2l[hst_addr[4:2]] = merge(m_h2l[hst_addr[4:2]], hst_wdata, hst_be);
                    lset[hst_addr[4:2]] = 1'b1;
                end else if (hst_addr == 16'h3060 && hst_be[2]) hclr = hst_wdata[23:16];
                else if (hst_addr == 16'h3070 && hst_be[2]) m_hena = hst_wdata[23:16];
            end
            m_lsts = (m_lsts & ~lclr) | lset;
            m_hsts = (m_hsts & ~hclr) | hset;
            m_lrd = lr; m_hrd = hr; m_lrv = lcl_rd; m_hrv = hst_rd;
            m_lirq = li; m_hirq = hi;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " lcl_rdata"}, lcl_rdata, m_lrd);
            chk({cur_req, " hst_rdata"}, hst_rdata, m_hrd);
            chk({cur_req, " lcl_irq/rvalid"}, {30'h0, lcl_irq, lcl_rvalid}, {30'h0, m_lirq, m_lrv});
            chk({cur_req, " hst_irq/rvalid"}, {30'h0, hst_irq, hst_rvalid}, {30'h0, m_hirq, m_hrv});
        end
    end

    task automatic lwr(logic [15:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        lcl_addr = a; lcl_be = be; lcl_wdata = d; lcl_wr = 1'b1;
        @(negedge clk);
        lcl_wr = 1'b0;
    endtask

    task automatic hwr(logic [15:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_be = be; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic bwr(logic [15:0] la, logic [31:0] ld, logic [15:0] ha, logic [31:0] hd);
        @(negedge clk);
        lcl_addr = la; lcl_be = 4'hF; lcl_wdata = ld; lcl_wr = 1'b1;
        hst_addr = ha; hst_be = 4'hF; hst_wdata = hd; hst_wr = 1'b1;
        @(negedge clk);
        lcl_wr = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic lrd_chk(string req, logic [15:0] a, logic [31:0] exp);
        @(negedge clk);
        lcl_addr = a; lcl_rd = 1'b1;
        @(negedge clk);
        lcl_rd = 1'b0;
        chk({req, " local read"}, lcl_rdata, exp);
        chk("R10 local rvalid", {31'h0, lcl_rvalid}, 32'h1);
    endtask

    task automatic hrd_chk(string req, logic [15:0] a, logic [31:0] exp);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        chk({req, " host read"}, hst_rdata, exp);
        chk("R10 host rvalid", {31'h0, hst_rvalid}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        chk("R1 lcl_irq", {31'h0, lcl_irq}, 32'h0);
        chk("R1 hst_rvalid", {31'h0, hst_rvalid}, 32'h0);
        lrd_chk("R1", 16'h3060, 32'h0);
        lrd_chk("R1", 16'h3070, 32'h0);
        lrd_chk("R1", 16'h3A00, 32'h0);
        hrd_chk("R1", 16'h3B1C, 32'h0);

        cur_req = "R2";
        lwr(16'h3A08, 4'hF, 32'hCAFE_0001);
        lrd_chk("R2", 16'h3A08, 32'hCAFE_0001);
        hrd_chk("R2", 16'h3A08, 32'hCAFE_0001);
        lwr(16'h3A08, 4'b0101, 32'h1122_3344);
        hrd_chk("R2", 16'h3A08, 32'hCA22_0044);
        hrd_chk("R4", 16'h3060, 32'h0004_0000);

        cur_req = "R3";
        lwr(16'h3B04, 4'hF, 32'hDEAD_BEEF);
        hrd_chk("R3", 16'h3B04, 32'h0);
        hrd_chk("R3", 16'h3060, 32'h0004_0000);
        hwr(16'h3A04, 4'hF, 32'hBEEF_DEAD);
        lrd_chk("R3", 16'h3A04, 32'h0);
        lrd_chk("R3", 16'h3060, 32'h0);

        cur_req = "R4";
        hwr(16'h3B0C, 4'hF, 32'h1234_5678);
        lrd_chk("R4", 16'h3060, 32'h0008_0000);
        lrd_chk("R4", 16'h3B0C, 32'h1234_5678);
        hwr(16'h3B10, 4'h0, 32'hFFFF_FFFF);
        lrd_chk("R4", 16'h3060, 32'h0008_0000);
        hrd_chk("R4", 16'h3B10, 32'h0);

        cur_req = "R5";
        lwr(16'h3060, 4'hF, 32'h0);
        lrd_chk("R5", 16'h3060, 32'h0008_0000);
        lwr(16'h3060, 4'b1011, 32'h0008_0000);
        lrd_chk("R5", 16'h3060, 32'h0008_0000);
        lwr(16'h3060, 4'b0100, 32'h0008_0000);
        lrd_chk("R5", 16'h3060, 32'h0);

        cur_req = "R6";
        hwr(16'h3B08, 4'hF, 32'h0000_00AA);
        bwr(16'h3060, 32'h0004_0000, 16'h3B08, 32'h0000_00BB);
        lrd_chk("R6", 16'h3060, 32'h0004_0000);
        lwr(16'h3060, 4'hF, 32'h0004_0000);
        lrd_chk("R6", 16'h3060, 32'h0);

        cur_req = "R7";
        lwr(16'h3070, 4'hF, 32'hFFFF_FFFF);
        lrd_chk("R8", 16'h3070, 32'h00FF_0000);
        lwr(16'h3070, 4'b1011, 32'h0);
        lrd_chk("R7", 16'h3070, 32'h00FF_0000);
        lwr(16'h3070, 4'hF, 32'h00A5_0000);
        lrd_chk("R7", 16'h3070, 32'h00A5_0000);

        cur_req = "R8";
        hwr(16'h3060, 4'hF, 32'hFF00_FFFF);
        hrd_chk("R8", 16'h3060, 32'h0004_0000);
        hwr(16'h3070, 4'hF, 32'hFF00_FFFF);
        hrd_chk("R8", 16'h3070, 32'h0);

        cur_req = "R9";
        hwr(16'h3B04, 4'hF, 32'h1);
        repeat (2) @(negedge clk);
        chk("R9 masked pending keeps irq low", {31'h0, lcl_irq}, 32'h0);
        hwr(16'h3B14, 4'hF, 32'h2);
        chk("R9 irq not yet high", {31'h0, lcl_irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq high next cycle", {31'h0, lcl_irq}, 32'h1);
        lwr(16'h3070, 4'hF, 32'h0);
        chk("R9 irq still high after mask edge", {31'h0, lcl_irq}, 32'h1);
        @(negedge clk);
        chk("R9 irq low after mask", {31'h0, lcl_irq}, 32'h0);
        lwr(16'h3070, 4'hF, 32'h0020_0000);
        @(negedge clk);
        chk("R9 irq back on unmask", {31'h0, lcl_irq}, 32'h1);
        lwr(16'h3060, 4'hF, 32'h0020_0000);
        @(negedge clk);
        chk("R9 irq low after clear", {31'h0, lcl_irq}, 32'h0);
        hwr(16'h3070, 4'hF, 32'h0004_0000);
        @(negedge clk);
        chk("R9 host irq", {31'h0, hst_irq}, 32'h1);

        cur_req = "R10";
        lrd_chk("R10", 16'h1000, 32'h0);
        lrd_chk("R10", 16'h3A0A, 32'h0);
        lwr(16'h3A01, 4'hF, 32'h5555_5555);
        lrd_chk("R10", 16'h3A00, 32'h0);
        @(negedge clk);
        chk("R10 idle rdata", lcl_rdata, 32'h0);

        cur_req = "R11";
        bwr(16'h3A1C, 32'hAAAA_5555, 16'h3B1C, 32'h5555_AAAA);
        hrd_chk("R11", 16'h3A1C, 32'hAAAA_5555);
        lrd_chk("R11", 16'h3B1C, 32'h5555_AAAA);
        lrd_chk("R11", 16'h3060, 32'h0082_0000);
        hrd_chk("R11", 16'h3060, 32'h0084_0000);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule